// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Condition-Code Register

This block is the arithmetic and logic core of a small accumulator machine. A five-bit operation code selects one function. The function is applied to the accumulator byte, to an operand byte (memory or index register), or to both. The result byte, the high product byte and the candidate flag values are produced combinationally in the same cycle. The code also yields a per-flag write mask and an indication of whether the result is meant to be written back.

The block holds the four condition-code flags in a register: half-carry H, negative N, zero Z and carry C. The arithmetic that takes a carry uses the registered C. When the execute strobe is high at a clock edge, only the flags enabled by the mask take their new values. Operand fetch and addressing are left to the surrounding sequencer. A compare of the index register is done by presenting the index register on the accumulator input.

Top module: `accAluCore`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) return accA + opnd (+ C for code 1) modulo 256. Mask 4'b1111 (bit order H,N,Z,C). C is the carry out of bit 7, H is the carry out of bit 3, N is result bit 7 and Z marks an all-zero result.
- R2: Codes 2 (subtract), 3 (subtract with borrow, using C) and 4 (compare) return accA - opnd (- C) modulo 256. Mask 4'b0111. C is set when opnd plus the incoming borrow exceeds accA. Compare drives resWrite low; codes 2 and 3 drive it high.
- R3: Codes 5 (AND), 6 (OR), 7 (XOR) and 8 (bit test, an AND) apply the bitwise function to accA and opnd with mask 4'b0110. Bit test drives resWrite low.
- R4: Codes 15, 16 and 17 act on opnd with mask 4'b0111.
  - Code 15 shifts left, filling zero; C takes bit 7.
  - Code 16 shifts right, keeping bit 7; C takes bit 0.
  - Code 17 shifts right, filling zero; C takes bit 0 and N ends at 0.
- R5: Code 18 rotates opnd left through C: old C goes to bit 0 and bit 7 goes to C. Code 19 rotates it right through C: old C goes to bit 7 and bit 0 goes to C. The mask is 4'b0111.
- R6: Code 9 returns 255 - opnd and sets C to 1. Code 10 returns 0 - opnd, with C set exactly when the result is nonzero. Both use mask 4'b0111.
- R7: Code 13 returns 0, leaving N at 0 and Z at 1. Code 14 returns opnd with resWrite low. Both use mask 4'b0110.
- R8: Code 20 returns the 16-bit unsigned product of accA and opnd, with the low byte on result and the high byte on resultHi. Mask 4'b1001 clears H and C. resultHi is zero for every other code.
- R9: Codes 11 (increment) and 12 (decrement) return opnd + 1 and opnd - 1, wrapping modulo 256. Mask 4'b0110, so C keeps its value.
- R10: Reset clears all four flags. At a clock edge with execEn high, each flag whose mask bit is set takes its new value and the others keep theirs. With execEn low, no flag changes.
- R11: Codes 21 to 31 are undefined: mask 0, resWrite low and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| execEn | input | 1 | Commits masked flags at the clock edge |
| opSel | input | 5 | Operation code |
| accA | input | 8 | Accumulator operand |
| opnd | input | 8 | Memory or index operand |
| result | output | 8 | Result byte (product low byte for multiply) |
| resultHi | output | 8 | Product high byte |
| resWrite | output | 1 | Result is meant to be written back |
| flagWe | output | 4 | Flag write mask {H,N,Z,C} |
| ccr | output | 4 | Registered flags {H,N,Z,C} |

## Verification
The embedded assertions watch the flag register on every cycle. They check that it holds when no execute strobe is given, and that unmasked flags survive a commit. They also check the fixed masks of the logic group and the undefined codes, the forced values after clear and multiply, and that the compare-like codes never request write-back. Only the bench scenarios can show the numeric behaviour: sums, borrows, the half-carry, shift and rotate bit movement, and product bytes. The bench checks these against its own model over random operands, with the carry-dependent codes exercised under both carry states.

// File: rtl/accAluPkg.sv
package accAluPkg;
  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int OP_W   = 5;
  localparam int FLAG_W = 4;
  // flag vector bit positions {H,N,Z,C}
  localparam int FH = 3;
  localparam int FN = 2;
  localparam int FZ = 1;
  localparam int FC = 0;

  localparam logic [OP_W-1:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,
                              OP_SBC = 5'd3,  OP_CMP = 5'd4,  OP_AND = 5'd5,
                              OP_ORA = 5'd6,  OP_EOR = 5'd7,  OP_BIT = 5'd8,
                              OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
                              OP_DEC = 5'd12, OP_CLR = 5'd13, OP_TST = 5'd14,
                              OP_ASL = 5'd15, OP_ASR = 5'd16, OP_LSR = 5'd17,
                              OP_ROL = 5'd18, OP_ROR = 5'd19, OP_MUL = 5'd20;

  typedef enum logic [2:0] {SRC_ADDER, SRC_LOGIC, SRC_SHIFT, SRC_MUL, SRC_ZERO} srcSelT;
  typedef enum logic [1:0] {ASEL_ACC, ASEL_OPND, ASEL_ZERO} aSelT;
  typedef enum logic [1:0] {BSEL_OPND, BSEL_ONE, BSEL_ZERO} bSelT;
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_C, CIN_NOTC} cinSelT;
  typedef enum logic [1:0] {LOG_AND, LOG_OR, LOG_XOR, LOG_NOT} logicOpT;
  typedef enum logic [2:0] {SH_ASL, SH_ASR, SH_LSR, SH_ROL, SH_ROR} shiftOpT;

  typedef struct packed {
    srcSelT            srcSel;
    aSelT              aSel;
    bSelT              bSel;
    logic              invB;
    cinSelT            cinSel;
    logic              isSub;
    logicOpT           logicOp;
    shiftOpT           shiftOp;
    logic [FLAG_W-1:0] mask;
    logic              resWrite;
  } ctrlT;
endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output ctrlT            ctrl
);
  localparam logic [FLAG_W-1:0] M_ALL = 4'b1111;
  localparam logic [FLAG_W-1:0] M_NZC = 4'b0111;
  localparam logic [FLAG_W-1:0] M_NZ  = 4'b0110;
  localparam logic [FLAG_W-1:0] M_HC  = 4'b1001;

  always_comb begin
    ctrl = '{srcSel: SRC_ADDER, aSel: ASEL_ACC, bSel: BSEL_OPND, invB: 1'b0,
             cinSel: CIN_ZERO, isSub: 1'b0, logicOp: LOG_AND, shiftOp: SH_ASL,
             mask: '0, resWrite: 1'b0};
    case (opSel)
      OP_ADD: begin ctrl.mask = M_ALL; ctrl.resWrite = 1'b1; end
      OP_ADC: begin ctrl.cinSel = CIN_C; ctrl.mask = M_ALL; ctrl.resWrite = 1'b1; end
      OP_SUB, OP_CMP: begin
        ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE; ctrl.isSub = 1'b1;
        ctrl.mask = M_NZC; ctrl.resWrite = (opSel == OP_SUB);
      end
      OP_SBC: begin
        ctrl.invB = 1'b1; ctrl.cinSel = CIN_NOTC; ctrl.isSub = 1'b1;
        ctrl.mask = M_NZC; ctrl.resWrite = 1'b1;
      end
      OP_AND, OP_BIT: begin
        ctrl.srcSel = SRC_LOGIC; ctrl.logicOp = LOG_AND;
        ctrl.mask = M_NZ; ctrl.resWrite = (opSel == OP_AND);
      end
      OP_ORA: begin ctrl.srcSel = SRC_LOGIC; ctrl.logicOp = LOG_OR;  ctrl.mask = M_NZ; ctrl.resWrite = 1'b1; end
      OP_EOR: begin ctrl.srcSel = SRC_LOGIC; ctrl.logicOp = LOG_XOR; ctrl.mask = M_NZ; ctrl.resWrite = 1'b1; end
      OP_COM: begin ctrl.srcSel = SRC_LOGIC; ctrl.logicOp = LOG_NOT; ctrl.mask = M_NZC; ctrl.resWrite = 1'b1; end
      OP_NEG: begin
        ctrl.aSel = ASEL_ZERO; ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE; ctrl.isSub = 1'b1;
        ctrl.mask = M_NZC; ctrl.resWrite = 1'b1;
      end
      OP_INC: begin ctrl.aSel = ASEL_OPND; ctrl.bSel = BSEL_ONE; ctrl.mask = M_NZ; ctrl.resWrite = 1'b1; end
      OP_DEC: begin
        ctrl.aSel = ASEL_OPND; ctrl.bSel = BSEL_ONE; ctrl.invB = 1'b1;
        ctrl.cinSel = CIN_ONE; ctrl.isSub = 1'b1; ctrl.mask = M_NZ; ctrl.resWrite = 1'b1;
      end
      OP_CLR: begin ctrl.srcSel = SRC_ZERO; ctrl.mask = M_NZ; ctrl.resWrite = 1'b1; end
      OP_TST: begin ctrl.aSel = ASEL_OPND; ctrl.bSel = BSEL_ZERO; ctrl.mask = M_NZ; end
      OP_ASL: begin ctrl.srcSel = SRC_SHIFT; ctrl.shiftOp = SH_ASL; ctrl.mask = M_NZC; ctrl.resWrite = 1'b1; end
      OP_ASR: begin ctrl.srcSel = SRC_SHIFT; ctrl.shiftOp = SH_ASR; ctrl.mask = M_NZC; ctrl.resWrite = 1'b1; end
      OP_LSR: begin ctrl.srcSel = SRC_SHIFT; ctrl.shiftOp = SH_LSR; ctrl.mask = M_NZC; ctrl.resWrite = 1'b1; end
      OP_ROL: begin ctrl.srcSel = SRC_SHIFT; ctrl.shiftOp = SH_ROL; ctrl.mask = M_NZC; ctrl.resWrite = 1'b1; end
      OP_ROR: begin ctrl.srcSel = SRC_SHIFT; ctrl.shiftOp = SH_ROR; ctrl.mask = M_NZC; ctrl.resWrite = 1'b1; end
      OP_MUL: begin ctrl.srcSel = SRC_MUL; ctrl.mask = M_HC; ctrl.resWrite = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/accAluDatapath.sv
module accAluDatapath
  import accAluPkg::*;
(
  input  ctrlT              ctrl,
  input  logic [DATA_W-1:0] accA,
  input  logic [DATA_W-1:0] opnd,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] resultHi,
  output logic [FLAG_W-1:0] flagVal
);
  logic [DATA_W-1:0]   aOp, bOp, bEff, logicRes, shiftRes;
  logic                cin, shiftC, addC, halfC, outC, outH;
  logic [DATA_W:0]     sum;
  logic [HALF_W:0]     lowSum;
  logic [2*DATA_W-1:0] product;

  always_comb begin
    case (ctrl.aSel)
      ASEL_OPND: aOp = opnd;
      ASEL_ZERO: aOp = '0;
      default:   aOp = accA;
    endcase
    case (ctrl.bSel)
      BSEL_ONE:  bOp = DATA_W'(1);
      BSEL_ZERO: bOp = '0;
      default:   bOp = opnd;
    endcase
    case (ctrl.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_C:    cin = carryIn;
      CIN_NOTC: cin = ~carryIn;
      default:  cin = 1'b0;
    endcase
    bEff   = ctrl.invB ? ~bOp : bOp;
    sum    = {1'b0, aOp} + {1'b0, bEff} + {{DATA_W{1'b0}}, cin};
    lowSum = {1'b0, aOp[HALF_W-1:0]} + {1'b0, bEff[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
    halfC  = lowSum[HALF_W];
    // subtraction carry is a borrow: inverted carry out
    addC   = ctrl.isSub ? ~sum[DATA_W] : sum[DATA_W];
  end

  always_comb begin
    case (ctrl.logicOp)
      LOG_OR:  logicRes = accA | opnd;
      LOG_XOR: logicRes = accA ^ opnd;
      LOG_NOT: logicRes = ~opnd;
      default: logicRes = accA & opnd;
    endcase
  end

  always_comb begin
    case (ctrl.shiftOp)
      SH_ASR:  begin shiftRes = {opnd[DATA_W-1], opnd[DATA_W-1:1]}; shiftC = opnd[0]; end
      SH_LSR:  begin shiftRes = {1'b0, opnd[DATA_W-1:1]};           shiftC = opnd[0]; end
      SH_ROL:  begin shiftRes = {opnd[DATA_W-2:0], carryIn};        shiftC = opnd[DATA_W-1]; end
      SH_ROR:  begin shiftRes = {carryIn, opnd[DATA_W-1:1]};        shiftC = opnd[0]; end
      default: begin shiftRes = {opnd[DATA_W-2:0], 1'b0};           shiftC = opnd[DATA_W-1]; end
    endcase
  end

  assign product = {{DATA_W{1'b0}}, accA} * {{DATA_W{1'b0}}, opnd};

  always_comb begin
    resultHi = '0;
    outH     = 1'b0;
    case (ctrl.srcSel)
      SRC_LOGIC: begin result = logicRes; outC = 1'b1; end
      SRC_SHIFT: begin result = shiftRes; outC = shiftC; end
      SRC_MUL:   begin result = product[DATA_W-1:0]; resultHi = product[2*DATA_W-1:DATA_W]; outC = 1'b0; end
      SRC_ZERO:  begin result = '0; outC = 1'b0; end
      default:   begin result = sum[DATA_W-1:0]; outC = addC; outH = halfC; end
    endcase
    flagVal[FH] = outH;
    flagVal[FN] = result[DATA_W-1];
    flagVal[FZ] = (result == '0);
    flagVal[FC] = outC;
  end
endmodule

// File: rtl/accAluCore.sv
module accAluCore
  import accAluPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        execEn,
  input  logic [4:0]  opSel,
  input  logic [7:0]  accA,
  input  logic [7:0]  opnd,
  output logic [7:0]  result,
  output logic [7:0]  resultHi,
  output logic        resWrite,
  output logic [3:0]  flagWe,
  output logic [3:0]  ccr
);
  ctrlT              ctrl;
  logic [FLAG_W-1:0] flagVal;
  logic [FLAG_W-1:0] ccrQ;

  accAluCtrl ctrl_i (.opSel(opSel), .ctrl(ctrl));

  accAluDatapath dp_i (
    .ctrl(ctrl), .accA(accA), .opnd(opnd), .carryIn(ccrQ[FC]),
    .result(result), .resultHi(resultHi), .flagVal(flagVal)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ccrQ <= '0;
    else if (execEn) ccrQ <= (ccrQ & ~ctrl.mask) | (flagVal & ctrl.mask);
  end

  assign ccr      = ccrQ;
  assign flagWe   = ctrl.mask;
  assign resWrite = ctrl.resWrite;

  AST_CCR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> $stable(ccr));  // R10
  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && !flagWe[FC]) |=> (ccr[FC] == $past(ccr[FC])));  // R10
  AST_LOGIC_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= OP_AND && opSel <= OP_BIT) |-> (flagWe == 4'b0110));  // R3
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && opSel == OP_CLR) |=> (ccr[FZ] && !ccr[FN]));  // R7
  AST_MUL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && opSel == OP_MUL) |=> (!ccr[FH] && !ccr[FC]));  // R8
  AST_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_CMP || opSel == OP_BIT || opSel == OP_TST) |-> !resWrite);  // R2
  AST_UNDEF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (opSel > OP_MUL) |-> (flagWe == '0 && !resWrite));  // R11
endmodule

// File: tb/accAluCore_tb.sv
module accAluCore_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       execEn = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] accA = '0, opnd = '0;
  logic [7:0] result, resultHi;
  logic       resWrite;
  logic [3:0] flagWe, ccr;

  int errors = 0;
  int checks = 0;
  logic [3:0] modelCcr = '0;
  bit done = 0;

  always #2 clk = ~clk;

  accAluCore dut_i (.clk(clk), .rstN(rstN), .execEn(execEn), .opSel(opSel),
    .accA(accA), .opnd(opnd), .result(result), .resultHi(resultHi),
    .resWrite(resWrite), .flagWe(flagWe), .ccr(ccr));

  function automatic string reqOf(input logic [4:0] op);
    if (op <= 1) return "R1";
    if (op <= 4) return "R2";
    if (op <= 8) return "R3";
    if (op == 9 || op == 10) return "R6";
    if (op == 11 || op == 12) return "R9";
    if (op == 13 || op == 14) return "R7";
    if (op <= 17) return "R4";
    if (op <= 19) return "R5";
    if (op == 20) return "R8";
    return "R11";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic [3:0] cc, output logic [7:0] r, output logic [7:0] hi,
                       output logic rw, output logic [3:0] mk, output logic [3:0] f);
    logic ci; logic h; logic c; logic [8:0] s; logic [15:0] p;
    ci = cc[0]; h = 0; c = 0; hi = 0; rw = 1; mk = 4'b0111; r = 0;
    case (op)
      0, 1: begin
        s = {1'b0, a} + {1'b0, m} + ((op == 1) ? {8'd0, ci} : 9'd0);
        r = s[7:0]; c = s[8]; mk = 4'b1111;
        h = ({1'b0, a[3:0]} + {1'b0, m[3:0]} + ((op == 1) ? {4'd0, ci} : 5'd0)) > 5'd15;
      end
      2, 3, 4: begin
        logic [8:0] sub;
        sub = {1'b0, m} + ((op == 3) ? {8'd0, ci} : 9'd0);
        r = a - sub[7:0]; c = sub > {1'b0, a}; rw = (op != 4);
      end
      5: begin r = a & m; mk = 4'b0110; end
      6: begin r = a | m; mk = 4'b0110; end
      7: begin r = a ^ m; mk = 4'b0110; end
      8: begin r = a & m; mk = 4'b0110; rw = 0; end
      9: begin r = 8'hFF - m; c = 1; end
      10: begin r = 8'h00 - m; c = (r != 0); end
      11: begin r = m + 1; mk = 4'b0110; end
      12: begin r = m - 1; mk = 4'b0110; end
      13: begin r = 0; mk = 4'b0110; end
      14: begin r = m; mk = 4'b0110; rw = 0; end
      15: begin r = {m[6:0], 1'b0}; c = m[7]; end
      16: begin r = {m[7], m[7:1]}; c = m[0]; end
      17: begin r = {1'b0, m[7:1]}; c = m[0]; end
      18: begin r = {m[6:0], ci}; c = m[7]; end
      19: begin r = {ci, m[7:1]}; c = m[0]; end
      20: begin p = {8'd0, a} * {8'd0, m}; r = p[7:0]; hi = p[15:8]; mk = 4'b1001; end
      default: begin mk = 0; rw = 0; end
    endcase
    f = {h, r[7], (r == 0), c};
  endtask

  // drive at negedge, check combinational outputs, commit at posedge, check ccr
  task automatic step(input logic [4:0] op, input logic [7:0] a, input logic [7:0] m, input logic en);
    logic [7:0] r, hi; logic rw; logic [3:0] mk, f; string rq;
    @(negedge clk);
    opSel = op; accA = a; opnd = m; execEn = en;
    model(op, a, m, modelCcr, r, hi, rw, mk, f);
    rq = reqOf(op);
    #1;
    if (op <= 20) chk(rq, "result", result, r);
    chk(rq, "resultHi", resultHi, hi);
    chk(rq, "resWrite", resWrite, rw);
    chk(rq, "flagWe", flagWe, mk);
    if (en) modelCcr = (modelCcr & ~mk) | (f & mk);
    @(negedge clk);
    execEn = 0;
    chk(en ? rq : "R10", "ccr", ccr, modelCcr);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    chk("R10", "ccr after reset", ccr, 0);
    rstN = 1;
    // R1 half-carry and carry-out corner cases
    step(0, 8'h0F, 8'h01, 1);
    step(0, 8'hFF, 8'h01, 1);
    step(1, 8'h7F, 8'h00, 1);   // carry in = 1 from previous
    // R2 borrow cases
    step(2, 8'h00, 8'h01, 1);
    step(3, 8'h05, 8'h05, 1);   // borrow in
    step(4, 8'h10, 8'h10, 1);
    // R6 COM and NEG zero
    step(9, 8'h00, 8'hFF, 1);
    step(10, 8'h00, 8'h00, 1);
    // R9 wrap, carry must survive
    step(0, 8'hFF, 8'hFF, 1);
    step(11, 8'h00, 8'hFF, 1);
    step(12, 8'h00, 8'h00, 1);
    // R7 clear and test
    step(13, 8'h55, 8'h80, 1);
    step(14, 8'h00, 8'h80, 1);
    // R4 LSR of all ones, R5 rotates with both carries
    step(17, 8'h00, 8'hFF, 1);
    step(18, 8'h00, 8'h80, 1);
    step(19, 8'h00, 8'h01, 1);
    step(16, 8'h00, 8'h81, 1);
    // R8 max product
    step(20, 8'hFF, 8'hFF, 1);
    // R10 hold without strobe; R11 undefined codes
    step(2, 8'h00, 8'h01, 0);
    step(21, 8'h12, 8'h34, 1);
    step(31, 8'h00, 8'h00, 1);
    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 22));
      step(op, 8'($urandom), 8'($urandom), ($urandom_range(0, 7) != 0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule